// File: doc/BRIEF.md
# Manual-Mode 10-Bit Word Aligner

The aligner takes an unaligned stream of 10-bit words from a deserializer, one word per parallel clock, and recovers the word boundary. It looks for a programmable 10-bit alignment pattern at every one of the ten bit offsets in a window made of the previous and the current input word, so a pattern that straddles two input words is found as well. The output is a stream of 10-bit words cut at the chosen boundary.

A level-sensitive realign enable decides when the boundary may move. While the enable is low the boundary stays fixed and matches elsewhere are ignored. While it is high, a match at a new offset moves the boundary. Two one-cycle status pulses accompany the output: `pattern_det_o` marks an output word that holds the pattern, and `sync_o` marks the word on which a new boundary took effect. Both pulses are delay-matched to the output data.

Within a word, bit 0 is the earliest bit received. A typical setting of `pattern_i` is the comma code 10'b0101111100. The pattern is held steady while the block is out of reset.

Top module: `word_align_manual`

## Requirements
- R1: The search window is {current word, previous word}, 20 bits. The candidate at offset k (0 to 9) is window bits [k+9:k]. The output word is the candidate at the selected offset, and the locked offset is always below 10.
- R2: The output has a fixed latency of two clocks. With offset 0 selected, `data_o` after clock edge n equals the `data_i` word sampled at edge n-2.
- R3: After reset `data_o`, `pattern_det_o` and `sync_o` are 0. The boundary is at offset 0 and is marked as not yet valid.
- R4: The enable is paired with the input word that holds window bit 0. On the first match seen with the enable high, after reset or after the enable rises, `sync_o` and `pattern_det_o` both pulse for one clock and the boundary moves to that offset. This happens even when that offset equals the current one.
- R5: A later match at the locked offset pulses only `pattern_det_o`. `sync_o` stays low, whatever the enable level.
- R6: A match at any other offset while the enable is low leaves the boundary unchanged and produces no pulse.
- R7: A match at a different offset while the enable is high moves the boundary there and pulses both outputs. Every change of the boundary comes with a `sync_o` pulse.
- R8: When several offsets match in the same cycle with the enable high, the lowest offset is chosen.
- R9: Each pulse coincides with the output word that holds the matched pattern: whenever `pattern_det_o` is high, `data_o` equals `pattern_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | W (10) | Unaligned input word, bit 0 earliest |
| pattern_i | input | W (10) | Alignment pattern, held steady out of reset |
| realign_en_i | input | 1 | Level enable that allows the boundary to move |
| data_o | output | W (10) | Aligned output word |
| pattern_det_o | output | 1 | One-clock pulse: the output word holds the pattern |
| sync_o | output | 1 | One-clock pulse: a new boundary took effect |

## Verification
The assertions assume that `pattern_i` does not change while reset is released. The pulse-word check compares the output against the live pattern input, so it would fire spuriously if the pattern moved under a word in flight. The bench changes the pattern only while reset is held. Between resets it switches from the comma code to an alternating pattern, so that several offsets match in the same cycle. Its enable changes at word granularity and covers held-high, held-low, rising and random sequences, so that every enable-to-word pairing is exercised.

// File: rtl/wa_pkg.sv
package wa_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_HIT   = 2'd1,
    ACT_ALIGN = 2'd2
  } wa_act_e;
endpackage

// File: rtl/wa_window.sv
module wa_window #(
  parameter int W = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   data_i,
  input  logic           en_i,
  output logic [2*W-1:0] win_o,
  output logic           en_o,
  output logic           rise_o
);
  logic [W-1:0] d1_q, d2_q;
  logic         e1_q, e2_q, e3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d1_q <= '0;
      d2_q <= '0;
      e1_q <= 1'b0;
      e2_q <= 1'b0;
      e3_q <= 1'b0;
    end else begin
      d1_q <= data_i;
      d2_q <= d1_q;
      e1_q <= en_i;
      e2_q <= e1_q;
      e3_q <= e2_q;
    end
  end

  // enable travels with the older word (window bit 0)
  assign win_o  = {d1_q, d2_q};
  assign en_o   = e2_q;
  assign rise_o = e2_q & ~e3_q;
endmodule

// File: rtl/wa_matcher.sv
module wa_matcher #(
  parameter int W  = 10,
  parameter int OW = $clog2(W)
) (
  input  logic [2*W-1:0] win_i,
  input  logic [W-1:0]   pattern_i,
  output logic [W-1:0]   hit_o,
  output logic           any_o,
  output logic [OW-1:0]  low_o
);
  for (genvar k = 0; k < W; k++) begin : g_cmp
    assign hit_o[k] = (win_i[k +: W] == pattern_i);
  end

  assign any_o = |hit_o;

  // lowest offset wins
  always_comb begin
    low_o = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (hit_o[k]) low_o = OW'(k);
    end
  end
endmodule

// File: rtl/wa_ctrl.sv
module wa_ctrl
  import wa_pkg::*;
#(
  parameter int W  = 10,
  parameter int OW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  hit_i,
  input  logic          any_i,
  input  logic [OW-1:0] low_i,
  input  logic          en_i,
  input  logic          rise_i,
  output wa_act_e       act_o,
  output logic [OW-1:0] sel_o,
  output logic [OW-1:0] off_o
);
  logic          valid_q, armed_q;
  logic [OW-1:0] off_q;
  logic          fresh;

  always_comb begin
    fresh = ~valid_q | armed_q | rise_i;
    act_o = ACT_NONE;
    sel_o = off_q;
    if (en_i && any_i) begin
      if (fresh || (low_i != off_q)) begin
        act_o = ACT_ALIGN;
        sel_o = low_i;
      end else begin
        act_o = ACT_HIT;
      end
    end else if (!en_i && valid_q && hit_i[off_q]) begin
      act_o = ACT_HIT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      armed_q <= 1'b0;
      off_q   <= '0;
    end else begin
      // armed: enable rose, no match consumed yet
      armed_q <= en_i & (armed_q | rise_i) & ~any_i;
      if (act_o == ACT_ALIGN) begin
        valid_q <= 1'b1;
        off_q   <= low_i;
      end
    end
  end

  assign off_o = off_q;

  assert_off_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(off_q) < W);

  assert_locked_when_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> $stable(off_q));
endmodule

// File: rtl/wa_shifter.sv
module wa_shifter
  import wa_pkg::*;
#(
  parameter int W  = 10,
  parameter int OW = $clog2(W)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2*W-1:0] win_i,
  input  logic [OW-1:0]  sel_i,
  input  wa_act_e        act_i,
  output logic [W-1:0]   data_o,
  output logic           det_o,
  output logic           sync_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      det_o  <= 1'b0;
      sync_o <= 1'b0;
    end else begin
      data_o <= win_i[sel_i +: W];
      det_o  <= (act_i != ACT_NONE);
      sync_o <= (act_i == ACT_ALIGN);
    end
  end
endmodule

// File: rtl/word_align_manual.sv
module word_align_manual
  import wa_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] pattern_i,
  input  logic         realign_en_i,
  output logic [W-1:0] data_o,
  output logic         pattern_det_o,
  output logic         sync_o
);
  localparam int OW = $clog2(W);

  logic [2*W-1:0] win;
  logic           en_old, en_rise;
  logic [W-1:0]   hit;
  logic           any_hit;
  logic [OW-1:0]  low_off, sel, off;
  wa_act_e        act;

  wa_window #(.W(W)) i_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .en_i   (realign_en_i),
    .win_o  (win),
    .en_o   (en_old),
    .rise_o (en_rise)
  );

  wa_matcher #(.W(W), .OW(OW)) i_matcher (
    .win_i     (win),
    .pattern_i (pattern_i),
    .hit_o     (hit),
    .any_o     (any_hit),
    .low_o     (low_off)
  );

  wa_ctrl #(.W(W), .OW(OW)) i_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .any_i  (any_hit),
    .low_i  (low_off),
    .en_i   (en_old),
    .rise_i (en_rise),
    .act_o  (act),
    .sel_o  (sel),
    .off_o  (off)
  );

  wa_shifter #(.W(W), .OW(OW)) i_shifter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .win_i  (win),
    .sel_i  (sel),
    .act_i  (act),
    .data_o (data_o),
    .det_o  (pattern_det_o),
    .sync_o (sync_o)
  );

  assert_sync_with_det_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> pattern_det_o);

  assert_boundary_move_sync_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(off) |-> sync_o);

  assert_pulse_word_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pattern_det_o |-> (data_o == pattern_i));
endmodule

// File: tb/test_word_align_manual.sv
`timescale 1ns/1ps
module test_word_align_manual;
  localparam logic [9:0] COMMA = 10'b0101111100;
  localparam logic [9:0] ALT   = 10'b0101010101;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] data_i = '0;
  logic [9:0] pattern_i = COMMA;
  logic       realign_en_i = 1'b0;
  logic [9:0] data_o;
  logic       pattern_det_o, sync_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  word_align_manual #(.W(10)) i_word_align_manual (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .data_i       (data_i),
    .pattern_i    (pattern_i),
    .realign_en_i (realign_en_i),
    .data_o       (data_o),
    .pattern_det_o(pattern_det_o),
    .sync_o       (sync_o)
  );

  // reference model state
  logic [9:0] pat;
  logic [9:0] m_h0, m_h1;
  bit         m_e1, m_ea, m_eb, m_valid, m_armed;
  int         m_off;
  bit         bq[$];

  task automatic model_reset();
    m_h0 = '0; m_h1 = '0;
    m_e1 = 0; m_ea = 0; m_eb = 0;
    m_valid = 0; m_armed = 0; m_off = 0;
    bq.delete();
  endtask

  task automatic do_reset(input logic [9:0] p);
    @(negedge clk_i);
    rst_ni = 1'b0; data_i = '0; realign_en_i = 1'b0;
    pattern_i = p; pat = p;
    model_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    n_chk++;
    if (data_o !== '0 || pattern_det_o !== 1'b0 || sync_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R3 reset: data=%h det=%b sync=%b expected data=000 det=0 sync=0",
               data_o, pattern_det_o, sync_o);
    end
  endtask

  task automatic step(input logic [9:0] w, input bit en, input string tag);
    logic [19:0] win;
    logic [9:0]  ex_data;
    bit          ex_det, ex_sync, cur_hit, rise, fresh;
    int          low, sel;
    @(negedge clk_i);
    data_i = w;
    realign_en_i = en;
    win = {m_h0, m_h1};
    low = -1; cur_hit = 0;
    for (int o = 0; o < 10; o++) begin
      if (win[o +: 10] == pat) begin
        if (low < 0) low = o;
        if (o == m_off) cur_hit = 1;
      end
    end
    rise  = m_ea && !m_eb;
    fresh = !m_valid || m_armed || rise;
    ex_det = 0; ex_sync = 0; sel = m_off;
    if (m_ea && low >= 0) begin
      ex_det = 1;
      if (fresh || low != m_off) begin ex_sync = 1; sel = low; end
    end else if (!m_ea && m_valid && cur_hit) begin
      ex_det = 1;
    end
    ex_data = win[sel +: 10];
    m_armed = m_ea && (m_armed || rise) && (low < 0);
    if (ex_sync) begin m_off = sel; m_valid = 1; end
    m_h1 = m_h0; m_h0 = w;
    m_eb = m_ea; m_ea = m_e1; m_e1 = en;
    @(posedge clk_i);
    #1;
    n_chk++;
    if (data_o !== ex_data || pattern_det_o !== ex_det || sync_o !== ex_sync) begin
      n_fail++;
      $display("FAIL %s: data=%h det=%b sync=%b expected data=%h det=%b sync=%b",
               tag, data_o, pattern_det_o, sync_o, ex_data, ex_det, ex_sync);
    end
    if (ex_det) begin
      n_chk++;
      if (data_o !== pat) begin
        n_fail++;
        $display("FAIL R9 pulse word: data=%h expected %h", data_o, pat);
      end
    end
  endtask

  task automatic emit(input bit en, input string tag);
    logic [9:0] w;
    while (bq.size() >= 10) begin
      for (int b = 0; b < 10; b++) w[b] = bq.pop_front();
      step(w, en, tag);
    end
  endtask

  task automatic push_word(input logic [9:0] w);
    for (int b = 0; b < 10; b++) bq.push_back(w[b]);
  endtask

  task automatic pad_flush(input bit en, input string tag);
    while (bq.size() % 10 != 0) bq.push_back(1'b0);
    for (int b = 0; b < 20; b++) bq.push_back(1'b0);
    emit(en, tag);
  endtask

  // pattern starting at stream bit offset off
  task automatic scen(input int off, input bit en, input string tag);
    for (int b = 0; b < off; b++) bq.push_back(1'b0);
    push_word(pat);
    pad_flush(en, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog R2: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset(COMMA);
    // R2: random words, enable low, offset 0
    for (int i = 0; i < 12; i++) step(10'($urandom()), 1'b0, "R2 latency");
    // R6: not yet aligned, enable low
    scen(3, 1'b0, "R6 no align while low");
    // R4: initial alignment at offset 3
    scen(3, 1'b1, "R4 first match");
    // R5: locked boundary, enable low
    scen(3, 1'b0, "R5 locked hit");
    // R6: other offset, enable low
    scen(7, 1'b0, "R6 other offset ignored");
    scen(3, 1'b0, "R6 boundary kept");
    // R7: realign to offset 7
    scen(7, 1'b1, "R7 realign");
    // R5: enable held high, same offset
    scen(7, 1'b1, "R5 repeat at locked offset");
    // R4: enable drops then rises, same offset
    for (int i = 0; i < 4; i++) step('0, 1'b0, "R4 enable low gap");
    scen(7, 1'b1, "R4 re-arm after rise");
    // R1: random stream with random enable
    for (int i = 0; i < 150; i++) begin
      bit en = 1'($urandom_range(0, 1));
      int fill = $urandom_range(0, 25);
      for (int b = 0; b < fill; b++) bq.push_back(1'($urandom()));
      push_word(pat);
      emit(en, "R1 random stream");
    end
    pad_flush(1'b0, "R1 random tail");
    // R8: periodic pattern, several offsets match at once
    do_reset(ALT);
    for (int i = 0; i < 6; i++) push_word(10'b0101010101);
    emit(1'b1, "R8 lowest offset");
    scen(1, 1'b1, "R8 shifted periodic");
    for (int i = 0; i < 40; i++) step(10'($urandom()), 1'($urandom_range(0, 1)), "R8 random");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule